// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block turns a data-space access request from a small 8-bit core into one canonical 12-bit data address. It also names the kind of storage that the address reaches. A request uses one of two address sources. In the direct form, a 7-bit in-bank offset is combined with the 5-bit bank held in the bank select input. In the indirect form, a 16-bit pointer supplies the address. When the pointer's top bit is set, the access goes to program memory instead of the data space, and only the low byte of the addressed program word is returned.

The offset inside a bank sets the region of the access:
- The lowest twelve offsets reach core registers that every bank shares.
- The next twenty offsets reach the peripheral area that belongs to each bank.
- The offsets after that reach general RAM, but only in banks enabled by a parameter mask.
- The top sixteen offsets reach a common RAM that every bank shares.

For the two shared regions, the decoder clears the bank field of the output address, so all aliases land on one register-file location. Reads of unimplemented space return zero, and writes to it are dropped. Writes through a pointer into program memory are dropped as well.

A program-memory read costs one extra cycle. A two-state machine manages that cycle:
- **ACC_IDLE** is the reset state. A program-memory read seen here raises `stall` for one cycle, and the transition PM_READ_START moves the machine to ACC_PM_WAIT. Every other request completes in the same cycle and the machine stays in ACC_IDLE (transition SINGLE_CYCLE).
- **ACC_PM_WAIT** holds `stall` low and presents the response. The transition PM_READ_DONE always returns the machine to ACC_IDLE on the next clock.

The requester holds its request stable while `stall` is high.

Top module: `dmem_addr_dec`

## Requirements
- R1: In a direct access (`req_ind`=0), the bank field `data_addr[11:7]` equals `bsr` and `data_addr[6:0]` equals `req_offset`, for the peripheral, general RAM and unimplemented regions.
- R2: In an indirect access whose `ptr[15]` is 0, the data address is `ptr[11:0]` (bank `ptr[11:7]`, offset `ptr[6:0]`). If any of `ptr[14:12]` is set, the region is unimplemented (code 4).
- R3: Offsets 00h to 0Bh give region code 0 (core) in every bank, and `data_addr` = {5'b0, offset}.
- R4: Offsets 0Ch to 1Fh give region code 1 (peripheral), and the bank is kept in `data_addr`.
- R5: Offsets 20h to 6Fh give region code 2 (general RAM) when bit `bank` of `GPR_BANK_MASK` is 1. Otherwise they give code 4 (unimplemented). The default mask enables banks 0 to 3.
- R6: Offsets 70h to 7Fh give region code 3 (common) in every bank, and `data_addr` = {5'b0, offset}.
- R7: A response in region code 4 returns `rd_data` = 0 and never raises `rf_we`. For codes 0 to 3, `rd_data` = `rf_rdata`, and a write raises `rf_we`.
- R8: An indirect access with `ptr[15]`=1 gives region code 5 with `pm_sel`=1 and `pm_addr` = `ptr[14:0]`. A read then returns `rd_data` = `pm_word_lo`.
- R9: An indirect write with `ptr[15]`=1 is ignored: `rf_we` stays 0 and `stall` stays 0.
- R10: A program-memory read raises `stall` (with `rsp_valid`=0) for exactly one cycle. In the next cycle `stall` is 0 and `rsp_valid` is 1. All other requests give `rsp_valid`=1 in the request cycle.
- R11: After reset, with no request, `stall`, `rsp_valid` and `rf_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ind | input | 1 | 1 = address from pointer, 0 = direct |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_offset | input | 7 | Direct in-bank offset |
| bsr | input | 5 | Bank select value for direct accesses |
| ptr | input | 16 | Indirect pointer |
| rf_rdata | input | 8 | Register-file read data at `data_addr` |
| pm_word_lo | input | 8 | Low byte of program word at `pm_addr` |
| data_addr | output | 12 | Canonical data address |
| region | output | 3 | Region code 0 to 5 |
| pm_sel | output | 1 | Access targets program memory |
| pm_addr | output | 15 | Program memory word address |
| stall | output | 1 | Extra wait cycle for a program-memory read |
| rsp_valid | output | 1 | Response valid this cycle |
| rf_we | output | 1 | Register-file write enable |
| rd_data | output | 8 | Read data returned to the core |

## Verification
The assertions assume that the requester keeps `req_valid`, `req_ind`, `req_wr` and `ptr` stable across the cycle in which `stall` is high. They also assume that the read-data inputs reflect the addresses the block drives.

The bench meets these assumptions by driving a whole request at a falling edge and holding it through a second cycle whenever it expects a program-memory read. It also serves `rf_rdata` and `pm_word_lo` from its own arrays, indexed by the outputs of the design.

The random requests draw offsets, banks and pointer values freely. Pointer high bits are weighted so that the program-memory, wide-pointer and banked cases all occur.

// File: rtl/dmem_dec_pkg.sv
package dmem_dec_pkg;

    typedef enum logic [2:0] {
        RGN_CORE   = 3'd0,
        RGN_PERIPH = 3'd1,
        RGN_GPR    = 3'd2,
        RGN_COMMON = 3'd3,
        RGN_UNIMPL = 3'd4,
        RGN_PROG   = 3'd5
    } region_e;

    typedef enum logic {
        ACC_IDLE    = 1'b0,
        ACC_PM_WAIT = 1'b1
    } acc_state_e;

    // last in-bank offset of each lower region; offsets above GPR_LAST are common
    localparam logic [6:0] CORE_LAST   = 7'h0B;
    localparam logic [6:0] PERIPH_LAST = 7'h1F;
    localparam logic [6:0] GPR_LAST    = 7'h6F;

endpackage

// File: rtl/dmem_src_sel.sv
module dmem_src_sel #(
    parameter int BANK_W = 5,
    parameter int OFS_W  = 7,
    parameter int PTR_W  = 16
) (
    input  logic              req_ind,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [BANK_W-1:0] bsr,
    input  logic [PTR_W-1:0]  ptr,
    output logic [BANK_W-1:0] bank,
    output logic [OFS_W-1:0]  ofs,
    output logic              pm_hit,
    output logic              wide_hit
);
    localparam int ADDR_W = BANK_W + OFS_W;

    always_comb begin
        if (req_ind) begin
            bank     = ptr[ADDR_W-1:OFS_W];
            ofs      = ptr[OFS_W-1:0];
            pm_hit   = ptr[PTR_W-1];
            wide_hit = !ptr[PTR_W-1] && (|ptr[PTR_W-2:ADDR_W]);
        end else begin
            bank     = bsr;
            ofs      = req_offset;
            pm_hit   = 1'b0;
            wide_hit = 1'b0;
        end
    end
endmodule

// File: rtl/dmem_region_cls.sv
module dmem_region_cls
    import dmem_dec_pkg::*;
#(
    parameter int BANK_W = 5,
    parameter int OFS_W  = 7,
    parameter logic [(1<<BANK_W)-1:0] GPR_BANK_MASK = '1
) (
    input  logic [BANK_W-1:0]        bank,
    input  logic [OFS_W-1:0]         ofs,
    input  logic                     pm_hit,
    input  logic                     wide_hit,
    output region_e                  region,
    output logic [BANK_W+OFS_W-1:0]  canon_addr
);
    localparam int NBANK = 1 << BANK_W;

    logic [NBANK-1:0] gpr_bank_hit;
    logic             gpr_ok;

    for (genvar b = 0; b < NBANK; b++) begin : g_gpr
        assign gpr_bank_hit[b] = GPR_BANK_MASK[b] && (bank == BANK_W'(b));
    end
    assign gpr_ok = |gpr_bank_hit;

    always_comb begin
        if (pm_hit)
            region = RGN_PROG;
        else if (wide_hit)
            region = RGN_UNIMPL;
        else if (ofs <= CORE_LAST)
            region = RGN_CORE;
        else if (ofs <= PERIPH_LAST)
            region = RGN_PERIPH;
        else if (ofs <= GPR_LAST)
            region = gpr_ok ? RGN_GPR : RGN_UNIMPL;
        else
            region = RGN_COMMON;
    end

    always_comb begin
        if (region == RGN_CORE || region == RGN_COMMON)
            canon_addr = {{BANK_W{1'b0}}, ofs};
        else
            canon_addr = {bank, ofs};
    end
endmodule

// File: rtl/dmem_pm_fsm.sv
module dmem_pm_fsm
    import dmem_dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pm_rd_req,
    output logic stall
);
    acc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        stall   = 1'b0;
        unique case (state_q)
            ACC_IDLE: begin
                if (pm_rd_req) begin
                    stall   = 1'b1;
                    state_d = ACC_PM_WAIT;
                end
            end
            ACC_PM_WAIT: begin
                state_d = ACC_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/dmem_addr_dec.sv
module dmem_addr_dec
    import dmem_dec_pkg::*;
#(
    parameter int BANK_W = 5,
    parameter int OFS_W  = 7,
    parameter int PTR_W  = 16,
    parameter int DATA_W = 8,
    parameter logic [(1<<BANK_W)-1:0] GPR_BANK_MASK = 32'h0000_000F
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_ind,
    input  logic                      req_wr,
    input  logic [OFS_W-1:0]          req_offset,
    input  logic [BANK_W-1:0]         bsr,
    input  logic [PTR_W-1:0]          ptr,
    input  logic [DATA_W-1:0]         rf_rdata,
    input  logic [DATA_W-1:0]         pm_word_lo,
    output logic [BANK_W+OFS_W-1:0]   data_addr,
    output logic [2:0]                region,
    output logic                      pm_sel,
    output logic [PTR_W-2:0]          pm_addr,
    output logic                      stall,
    output logic                      rsp_valid,
    output logic                      rf_we,
    output logic [DATA_W-1:0]         rd_data
);
    logic [BANK_W-1:0] bank;
    logic [OFS_W-1:0]  ofs;
    logic              pm_hit, wide_hit;
    region_e           rgn;

    dmem_src_sel #(.BANK_W(BANK_W), .OFS_W(OFS_W), .PTR_W(PTR_W)) u_src (
        .req_ind(req_ind), .req_offset(req_offset), .bsr(bsr), .ptr(ptr),
        .bank(bank), .ofs(ofs), .pm_hit(pm_hit), .wide_hit(wide_hit)
    );

    dmem_region_cls #(.BANK_W(BANK_W), .OFS_W(OFS_W),
                      .GPR_BANK_MASK(GPR_BANK_MASK)) u_cls (
        .bank(bank), .ofs(ofs), .pm_hit(pm_hit), .wide_hit(wide_hit),
        .region(rgn), .canon_addr(data_addr)
    );

    dmem_pm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pm_rd_req(req_valid && pm_hit && !req_wr),
        .stall(stall)
    );

    assign region    = rgn;
    assign pm_sel    = pm_hit;
    assign pm_addr   = ptr[PTR_W-2:0];
    assign rsp_valid = req_valid && !stall;
    assign rf_we     = req_valid && req_wr && !pm_hit && (rgn != RGN_UNIMPL);

    always_comb begin
        if (pm_hit)                rd_data = pm_word_lo;
        else if (rgn == RGN_UNIMPL) rd_data = '0;
        else                        rd_data = rf_rdata;
    end
endmodule

// File: rtl/dmem_addr_dec_chk.sv
module dmem_addr_dec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_wr,
    input logic [11:0] data_addr,
    input logic [2:0]  region,
    input logic        pm_sel,
    input logic        stall,
    input logic        rsp_valid,
    input logic        rf_we,
    input logic [7:0]  rd_data,
    input logic [7:0]  pm_word_lo
);
    // R10
    one_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
    // R10
    stall_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!rsp_valid && pm_sel && !req_wr));
    // R10
    stall_then_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> rsp_valid);
    // R7
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && region == 3'd4) |-> (rd_data == 8'h00 && !rf_we));
    // R9
    pm_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pm_sel && req_wr) |-> (!rf_we && !stall));
    // R3
    shared_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == 3'd0 || region == 3'd3) |-> (data_addr[11:7] == 5'd0));
    // R8
    pm_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && pm_sel && !req_wr) |-> (rd_data == pm_word_lo && region == 3'd5));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!stall && !rf_we && !rsp_valid));
endmodule

bind dmem_addr_dec dmem_addr_dec_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .data_addr(data_addr), .region(region), .pm_sel(pm_sel), .stall(stall),
    .rsp_valid(rsp_valid), .rf_we(rf_we), .rd_data(rd_data), .pm_word_lo(pm_word_lo)
);

// File: tb/dmem_addr_dec_tb.sv
module dmem_addr_dec_tb_top;
    localparam logic [31:0] MASK = 32'h0000_000F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ind = 1'b0, req_wr = 1'b0;
    logic [6:0]  req_offset = '0;
    logic [4:0]  bsr = '0;
    logic [15:0] ptr = '0;
    logic [7:0]  rf_rdata, pm_word_lo;
    logic [11:0] data_addr;
    logic [2:0]  region;
    logic        pm_sel, stall, rsp_valid, rf_we;
    logic [14:0] pm_addr;
    logic [7:0]  rd_data;

    logic [7:0]  rf_mem [4096];
    logic [7:0]  pm_mem [1024];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dmem_addr_dec #(.GPR_BANK_MASK(MASK)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ind(req_ind),
        .req_wr(req_wr), .req_offset(req_offset), .bsr(bsr), .ptr(ptr),
        .rf_rdata(rf_rdata), .pm_word_lo(pm_word_lo), .data_addr(data_addr),
        .region(region), .pm_sel(pm_sel), .pm_addr(pm_addr), .stall(stall),
        .rsp_valid(rsp_valid), .rf_we(rf_we), .rd_data(rd_data)
    );

    always_comb rf_rdata   = rf_mem[data_addr];
    always_comb pm_word_lo = pm_mem[pm_addr[9:0]];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_region(input logic ind, input logic [6:0] off,
                                              input logic [4:0] b, input logic [15:0] p);
        logic [4:0] bk; logic [6:0] o;
        if (ind && p[15]) return 3'd5;
        if (ind && p[14:12] != 0) return 3'd4;
        bk = ind ? p[11:7] : b;
        o  = ind ? p[6:0]  : off;
        if (o <= 7'h0B) return 3'd0;
        if (o <= 7'h1F) return 3'd1;
        if (o <= 7'h6F) return MASK[bk] ? 3'd2 : 3'd4;
        return 3'd3;
    endfunction

    function automatic logic [11:0] exp_addr(input logic ind, input logic [6:0] off,
                                             input logic [4:0] b, input logic [15:0] p,
                                             input logic [2:0] rg);
        logic [4:0] bk; logic [6:0] o;
        bk = ind ? p[11:7] : b;
        o  = ind ? p[6:0]  : off;
        if (rg == 3'd0 || rg == 3'd3) return {5'd0, o};
        return {bk, o};
    endfunction

    task automatic txn(input logic ind, input logic wr, input logic [6:0] off,
                       input logic [4:0] b, input logic [15:0] p);
        logic [2:0]  rg;
        logic [11:0] ea;
        logic [7:0]  ed;
        bit          pm_rd;
        @(negedge clk);
        req_valid = 1'b1; req_ind = ind; req_wr = wr;
        req_offset = off; bsr = b; ptr = p;
        rg = exp_region(ind, off, b, p);
        ea = exp_addr(ind, off, b, p, rg);
        pm_rd = (rg == 3'd5) && !wr;
        #1;
        if (pm_rd) begin
            chk("R10 stall first cycle", {stall, rsp_valid}, 2'b10);
            @(negedge clk); #1;
            chk("R10 response second cycle", {stall, rsp_valid}, 2'b01);
        end else begin
            chk("R10/R9 single cycle", {stall, rsp_valid}, 2'b01);
        end
        chk("R3-R6 region", region, rg);
        if (rg == 3'd5) begin
            chk("R8 pm_sel/pm_addr", {pm_sel, pm_addr}, {1'b1, p[14:0]});
            if (!wr) chk("R8 program read data", rd_data, pm_mem[p[9:0]]);
            else     chk("R9 program write ignored", rf_we, 1'b0);
        end else begin
            chk(ind ? "R2 pointer address" : "R1 direct address", data_addr, ea);
            chk("R8 pm_sel low", pm_sel, 1'b0);
            if (rg == 3'd4) begin
                chk("R7 unimplemented read zero", rd_data, 8'h00);
                chk("R7 unimplemented no write", rf_we, 1'b0);
            end else begin
                ed = rf_mem[ea];
                chk("R7 register read data", rd_data, ed);
                chk("R7 write enable", rf_we, wr);
            end
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 4096; i++) rf_mem[i] = 8'((i * 7 + 3) ^ (i >> 5));
        for (int i = 0; i < 1024; i++) pm_mem[i] = 8'((i * 13) ^ 8'hA5);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11 reset idle outputs", {stall, rsp_valid, rf_we}, 3'b000);

        // directed boundaries, direct mode
        txn(0, 0, 7'h00, 5'd9,  '0);   // R3 core
        txn(0, 0, 7'h0B, 5'd17, '0);   // R3 last core
        txn(0, 0, 7'h0C, 5'd17, '0);   // R4 first peripheral
        txn(0, 1, 7'h1F, 5'd2,  '0);   // R4 last peripheral, write
        txn(0, 0, 7'h20, 5'd0,  '0);   // R5 GPR enabled bank
        txn(0, 1, 7'h6F, 5'd3,  '0);   // R5 GPR last, write
        txn(0, 0, 7'h40, 5'd5,  '0);   // R5 masked-off bank
        txn(0, 1, 7'h20, 5'd31, '0);   // R5/R7 masked-off write
        txn(0, 0, 7'h70, 5'd12, '0);   // R6 common first
        txn(0, 1, 7'h7F, 5'd30, '0);   // R6 common last
        // indirect
        txn(1, 0, 7'h00, 5'd0, 16'h0123); // R2
        txn(1, 0, 7'h00, 5'd0, 16'h1123); // R2 wide pointer
        txn(1, 0, 7'h00, 5'd0, 16'h8123); // R8/R10 program read
        txn(1, 0, 7'h00, 5'd0, 16'hFFFF); // R8 program read
        txn(1, 1, 7'h00, 5'd0, 16'h8040); // R9 program write
        txn(1, 0, 7'h00, 5'd0, 16'h8002); // R10 back-to-back after write

        for (int n = 0; n < 400; n++) begin
            logic [15:0] p;
            logic [2:0]  sel;
            p   = 16'($urandom);
            sel = 3'($urandom_range(0, 4));
            if (sel == 0) p[15:12] = 4'b0000;
            else if (sel == 1) p[15] = 1'b1;
            else if (sel == 2) p[15:12] = {1'b0, 3'($urandom_range(1, 7))};
            txn(1'($urandom), 1'($urandom), 7'($urandom), 5'($urandom), p);
        end

        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R11 idle after traffic", {stall, rsp_valid, rf_we}, 3'b000);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule